// File: doc/BRIEF.md
# UART register and command controller

This block is the byte-wide, memory-mapped control front end of a simple UART. A host reads and writes registers inside a 64-byte window, where only the low six address bits are decoded. Through that window it sets up two mode bytes, reads the line status, issues packed command bytes, loads transmit bytes, drains a small receive FIFO, reads the pending interrupt causes and sets the interrupt mask. The two baud-divider bytes are read-only and are fixed by parameters.

On the line side, a receive handshake pushes bytes into the FIFO. A one-cycle break pulse records a break event as a zero byte. A single transmit holding byte goes to an external shifter through a one-cycle strobe. The block drives one registered, level-sensitive interrupt line, which is the OR of the interrupt causes that the mask enables. Bit timing, parity, break generation and input-port change detection belong to other blocks.

Top module: `uart_regctl`

## Requirements
- R1: After reset the status byte reads 0x08 (transmitter empty only). Both mode bytes, the interrupt status and the interrupt mask read 0. `irq` and `rx_ready` are low. The transmitter and receiver are disabled.
- R2: Only `bus_addr[5:0]` is decoded. Reads: 0x00 mode, 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 upper divider byte, 0x1C lower divider byte. Writes: 0x00 mode, 0x08 command, 0x0C transmit byte, 0x14 interrupt mask. Reads of 0x08, 0x10 and every other offset return 0. Writes to 0x04, 0x10 and other offsets change nothing.
- R3: Offset 0x00 reaches the mode byte picked by a pointer that resets to the first byte. Every write there stores the data and moves the pointer to the second byte. Reads do not move the pointer. Command code 1 in bits [6:4] moves it back to the first byte.
- R4: Command bits [6:4] select an action. Code 2 disables the receiver and empties the FIFO. Code 3 disables the transmitter and sets transmitter-empty, dropping any held byte. Code 5 clears the break-change cause. Codes 0, 4, 6 and 7 change nothing.
- R5: Command bits [3:2] act on the transmitter and bits [1:0] act on the receiver. In each field 1 enables, 2 disables, and 0 and 3 change nothing. The action field is applied first, then the transmitter field, then the receiver field.
- R6: A write to offset 0x0C clears status bit 3 (transmitter empty) and holds the byte. If the transmitter is enabled, `tx_valid` is high for the one cycle after the write, with the byte on `tx_data`, and bit 3 is set again. A byte written while the transmitter is disabled is sent the cycle after a transmitter-enable command.
- R7: Status bit 2 (transmitter ready) equals the transmitter enable. Bit 0 (receive data ready) is set while the FIFO holds data. Bit 1 (FIFO full) is set when it holds 4 bytes. Bits 7..4 read 0. `rx_ready` is high when the receiver is enabled, the FIFO is not full and no break is present. A read of 0x0C returns the oldest byte and removes it; on an empty FIFO the read returns 0.
- R8: A `rx_break` pulse sets interrupt status bit 2 and pushes 0x00 even when the receiver is disabled. When the FIFO is full, the 0x00 replaces the newest byte.
- R9: Interrupt status bit 0 equals transmitter ready. Bit 1 equals FIFO full when bit 6 of the first mode byte is 1, and receive data ready otherwise. Bits 7..3 read 0.
- R10: `irq` is registered. It equals the OR of (interrupt status AND mask), taken from the state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address, decoded modulo 64 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive byte accepted when high |
| rx_break | input | 1 | One-cycle break-detected pulse |
| tx_valid | output | 1 | One-cycle strobe to the shifter |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a full FIFO meeting a break while the receiver is disabled. Only then does the overwrite of the newest byte show. The stimulus fills the FIFO through the handshake, disables the receiver with a command byte, and then pulses the break. It drains the FIFO to see three original bytes followed by a zero. A second hard case is a transmit byte loaded while the transmitter is disabled, which must leave only when an enable command arrives.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    localparam int unsigned WIN_BITS = 6;
    typedef logic [WIN_BITS-1:0] reg_off_t;

    localparam reg_off_t OFF_MODE = 6'h00;
    localparam reg_off_t OFF_STAT = 6'h04;
    localparam reg_off_t OFF_CMD  = 6'h08;
    localparam reg_off_t OFF_DATA = 6'h0C;
    localparam reg_off_t OFF_INT  = 6'h14;
    localparam reg_off_t OFF_DIVH = 6'h18;
    localparam reg_off_t OFF_DIVL = 6'h1C;

    localparam int unsigned RXSEL_BIT = 6;

    typedef enum logic [2:0] {
        ACT_NOP, ACT_PTR_HOME, ACT_RX_RESET, ACT_TX_RESET,
        ACT_ERR_CLR, ACT_BRK_ACK, ACT_BRK_ON, ACT_BRK_OFF
    } act_cmd_e;

    typedef enum logic [1:0] {
        PATH_KEEP, PATH_ON, PATH_OFF, PATH_RSVD
    } path_cmd_e;

    typedef struct packed {
        logic [1:0][7:0] mode;
        logic            mode_ptr;
        logic            rx_en;
        logic            brk_delta;
        logic [7:0]      int_mask;
    } ctl_state_t;

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [CNT_W-1:0]         cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else begin
            if (pop && st_q.cnt != '0) begin
                for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                    st_d.mem[i] = st_q.mem[i+1];
                end
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (push) begin
                if (st_d.cnt == CNT_MAX) begin
                    st_d.cnt = st_d.cnt - 1'b1;
                end
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (CNT_W'(i) == st_d.cnt) begin
                        st_d.mem[i] = push_data;
                    end
                end
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[0];
    assign full  = (st_q.cnt == CNT_MAX);
    assign empty = (st_q.cnt == '0);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> !empty);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          path_reset,
    input  logic          turn_on,
    input  logic          turn_off,
    output logic          en,
    output logic          empty,
    output logic          strobe,
    output logic [DW-1:0] hold_data
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic          en;
        logic          empty;
        logic          strobe;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (load) begin
            st_d.hold  = load_data;
            st_d.empty = 1'b0;
        end
        if (path_reset) begin
            st_d.en    = 1'b0;
            st_d.empty = 1'b1;
        end
        if (turn_on) begin
            st_d.en = 1'b1;
        end
        if (turn_off) begin
            st_d.en = 1'b0;
        end
        if (st_d.en && !st_d.empty) begin
            st_d.strobe = 1'b1;
            st_d.empty  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hold: '0, en: 1'b0, empty: 1'b1, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en        = st_q.en;
    assign empty     = st_q.empty;
    assign strobe    = st_q.strobe;
    assign hold_data = st_q.hold;

    assert_strobe_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (en && empty));

    assert_load_sent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en && !turn_off) |=> strobe);

    assert_path_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (path_reset && !turn_on) |=> (empty && !en));

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_rdy,
    input  logic       rx_rdy,
    input  logic       rx_full,
    input  logic       rx_sel_full,
    input  logic       brk_delta,
    input  logic [7:0] int_mask,
    output logic [7:0] int_status,
    output logic       irq
);
    logic rx_cause;
    logic irq_d, irq_q;

    always_comb begin
        rx_cause   = rx_sel_full ? rx_full : rx_rdy;
        int_status = {5'b0, brk_delta, rx_cause, tx_rdy};
        irq_d      = |(int_status & int_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(int_mask != 8'h00));

    assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 8'h00) |=> !irq);

endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter logic [7:0]  DIV_UPPER  = 8'h01,
    parameter logic [7:0]  DIV_LOWER  = 8'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              rx_break,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int unsigned DW = 8;

    ctl_state_t ctl_d, ctl_q;

    reg_off_t   off;
    logic       wr_any, rd_any;
    logic       wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
    act_cmd_e   act;
    path_cmd_e  tx_cmd, rx_cmd;
    logic       tx_rst, tx_on, tx_off;
    logic       fifo_flush, fifo_push;
    logic [DW-1:0] fifo_head, push_byte;
    logic       fifo_full, fifo_empty;
    logic       tx_en, tx_empty;
    logic [7:0] status, int_status;

    generate
        if (ADDR_W > WIN_BITS) begin : g_hi_addr
            logic unused_addr_hi;
            assign unused_addr_hi = ^bus_addr[ADDR_W-1:WIN_BITS];
        end
    endgenerate

    always_comb begin
        off     = bus_addr[WIN_BITS-1:0];
        wr_any  = bus_valid && bus_write;
        rd_any  = bus_valid && !bus_write;
        wr_mode = wr_any && (off == OFF_MODE);
        wr_cmd  = wr_any && (off == OFF_CMD);
        wr_data = wr_any && (off == OFF_DATA);
        wr_mask = wr_any && (off == OFF_INT);
        rd_data = rd_any && (off == OFF_DATA);
        act     = act_cmd_e'(bus_wdata[6:4]);
        tx_cmd  = path_cmd_e'(bus_wdata[3:2]);
        rx_cmd  = path_cmd_e'(bus_wdata[1:0]);
        tx_rst  = wr_cmd && (act == ACT_TX_RESET);
        tx_on   = wr_cmd && (tx_cmd == PATH_ON);
        tx_off  = wr_cmd && (tx_cmd == PATH_OFF);
        fifo_flush = wr_cmd && (act == ACT_RX_RESET);
        rx_ready   = ctl_q.rx_en && !fifo_full && !rx_break;
        fifo_push  = rx_break || (rx_valid && rx_ready);
        push_byte  = rx_break ? '0 : rx_data;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_mode) begin
            ctl_d.mode[ctl_q.mode_ptr] = bus_wdata;
            ctl_d.mode_ptr             = 1'b1;
        end
        if (wr_mask) begin
            ctl_d.int_mask = bus_wdata;
        end
        if (wr_cmd) begin
            case (act)
                ACT_PTR_HOME: ctl_d.mode_ptr  = 1'b0;
                ACT_RX_RESET: ctl_d.rx_en     = 1'b0;
                ACT_BRK_ACK:  ctl_d.brk_delta = 1'b0;
                default: ;
            endcase
            case (rx_cmd)
                PATH_ON:  ctl_d.rx_en = 1'b1;
                PATH_OFF: ctl_d.rx_en = 1'b0;
                default: ;
            endcase
        end
        if (rx_break) begin
            ctl_d.brk_delta = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .pop       (rd_data),
        .push      (fifo_push),
        .push_data (push_byte),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_tx_hold #(.DW(DW)) u_tx_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_data),
        .load_data  (bus_wdata),
        .path_reset (tx_rst),
        .turn_on    (tx_on),
        .turn_off   (tx_off),
        .en         (tx_en),
        .empty      (tx_empty),
        .strobe     (tx_valid),
        .hold_data  (tx_data)
    );

    uart_irq_gen u_irq_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rdy      (tx_en),
        .rx_rdy      (!fifo_empty),
        .rx_full     (fifo_full),
        .rx_sel_full (ctl_q.mode[0][RXSEL_BIT]),
        .brk_delta   (ctl_q.brk_delta),
        .int_mask    (ctl_q.int_mask),
        .int_status  (int_status),
        .irq         (irq)
    );

    always_comb begin
        status = {4'b0, tx_empty, tx_en, fifo_full, !fifo_empty};
        case (off)
            OFF_MODE: bus_rdata = ctl_q.mode[ctl_q.mode_ptr];
            OFF_STAT: bus_rdata = status;
            OFF_DATA: bus_rdata = fifo_empty ? 8'h00 : fifo_head;
            OFF_INT:  bus_rdata = int_status;
            OFF_DIVH: bus_rdata = DIV_UPPER;
            OFF_DIVL: bus_rdata = DIV_LOWER;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assert_mode_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> ctl_q.mode_ptr);

    assert_rx_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !fifo_flush) |=> !fifo_empty);

    assert_break_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> int_status[2]);

endmodule

// File: tb/uart_regctl_bench.sv
`timescale 1ns/1ps
module uart_regctl_bench;
    localparam int DEPTH = 4;
    localparam logic [7:0] DIVH = 8'h01;
    localparam logic [7:0] DIVL = 8'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_valid = 1'b0, b_write = 1'b0;
    logic [7:0] b_addr = '0, b_wdata = '0;
    logic [7:0] rdata;
    logic rxv = 1'b0, rxb = 1'b0;
    logic [7:0] rxd = '0;
    logic rx_ready, tx_valid, irq;
    logic [7:0] tx_data;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_regctl #(.ADDR_W(8), .FIFO_DEPTH(DEPTH), .DIV_UPPER(DIVH), .DIV_LOWER(DIVL)) u_uart_regctl (
        .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_write(b_write),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
        .rx_valid(rxv), .rx_data(rxd), .rx_ready(rx_ready), .rx_break(rxb),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // behavioural reference model
    byte unsigned m_mode[2];
    int  m_ptr;
    bit  m_txen, m_txemp, m_rxen, m_dbrk, m_irq, m_txv;
    byte unsigned m_hold, m_txd, m_imr;
    byte unsigned m_q[$];

    function automatic byte unsigned m_isr();
        bit rxc = m_mode[0][6] ? (m_q.size() == DEPTH) : (m_q.size() != 0);
        return {5'b0, m_dbrk, rxc, m_txen};
    endfunction

    function automatic byte unsigned m_read(byte unsigned a);
        case (a & 8'h3F)
            8'h00: return m_mode[m_ptr];
            8'h04: return {4'b0, m_txemp, m_txen, m_q.size() == DEPTH, m_q.size() != 0};
            8'h0C: return (m_q.size() != 0) ? m_q[0] : 8'h00;
            8'h14: return m_isr();
            8'h18: return DIVH;
            8'h1C: return DIVL;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode[0] = 0; m_mode[1] = 0; m_ptr = 0;
            m_txen = 0; m_txemp = 1; m_rxen = 0; m_dbrk = 0;
            m_irq = 0; m_txv = 0; m_hold = 0; m_txd = 0; m_imr = 0;
            m_q.delete();
        end else begin
            bit acc, flush;
            byte unsigned a;
            a = b_addr & 8'h3F;
            acc = rxv && m_rxen && (m_q.size() < DEPTH) && !rxb;
            flush = 0;
            m_irq = (m_isr() & m_imr) != 0;
            m_txv = 0;
            if (b_valid && !b_write && a == 8'h0C && m_q.size() != 0) void'(m_q.pop_front());
            if (b_valid && b_write) begin
                case (a)
                    8'h00: begin m_mode[m_ptr] = b_wdata; m_ptr = 1; end
                    8'h08: begin
                        case (b_wdata[6:4])
                            3'd1: m_ptr = 0;
                            3'd2: begin m_rxen = 0; m_q.delete(); flush = 1; end
                            3'd3: begin m_txen = 0; m_txemp = 1; end
                            3'd5: m_dbrk = 0;
                            default: ;
                        endcase
                        if (b_wdata[3:2] == 2'd1) begin
                            m_txen = 1;
                            if (!m_txemp) begin m_txv = 1; m_txd = m_hold; m_txemp = 1; end
                        end else if (b_wdata[3:2] == 2'd2) m_txen = 0;
                        if (b_wdata[1:0] == 2'd1) m_rxen = 1;
                        else if (b_wdata[1:0] == 2'd2) m_rxen = 0;
                    end
                    8'h0C: begin
                        m_hold = b_wdata; m_txemp = 0;
                        if (m_txen) begin m_txv = 1; m_txd = m_hold; m_txemp = 1; end
                    end
                    8'h14: m_imr = b_wdata;
                    default: ;
                endcase
            end
            if (rxb) begin
                m_dbrk = 1;
                if (!flush) begin
                    if (m_q.size() == DEPTH) void'(m_q.pop_back());
                    m_q.push_back(8'h00);
                end
            end else if (acc && !flush) begin
                m_q.push_back(rxd);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 irq vs model", irq, m_irq);
            chk("R6 tx_valid vs model", tx_valid, m_txv);
            if (m_txv) chk("R6 tx_data vs model", tx_data, m_txd);
            chk("R7 rx_ready vs model", rx_ready,
                m_rxen && (m_q.size() < DEPTH) && !rxb);
            if (b_valid && !b_write) chk("R2 rdata vs model", rdata, m_read(b_addr));
        end
    end

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic wr(byte unsigned a, byte unsigned d);
        b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
        @(posedge clk); #1;
        b_valid = 0; b_write = 0;
    endtask

    task automatic rd_chk(byte unsigned a, byte unsigned exp, string tag);
        b_valid = 1; b_write = 0; b_addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        @(posedge clk); #1;
        b_valid = 0;
    endtask

    task automatic push(byte unsigned d);
        rxv = 1; rxd = d;
        @(posedge clk); #1;
        rxv = 0;
    endtask

    task automatic brk();
        rxb = 1;
        @(posedge clk); #1;
        rxb = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle();
        // R1 reset state
        rd_chk(8'h04, 8'h08, "R1 status");
        rd_chk(8'h14, 8'h00, "R1 int status");
        rd_chk(8'h00, 8'h00, "R1 mode");
        chk("R1 irq", irq, 0);
        chk("R1 rx_ready", rx_ready, 0);
        // R3 mode pointer
        wr(8'h00, 8'h40);
        wr(8'h00, 8'h13);
        rd_chk(8'h00, 8'h13, "R3 second mode");
        rd_chk(8'h00, 8'h13, "R3 read keeps pointer");
        wr(8'h08, 8'h10);
        rd_chk(8'h00, 8'h40, "R3 pointer home");
        // R2 decode and ignored writes
        wr(8'h04, 8'hFF);
        wr(8'h10, 8'hFF);
        wr(8'h20, 8'hFF);
        rd_chk(8'h44, 8'h08, "R2 alias status");
        rd_chk(8'h10, 8'h00, "R2 aux reads zero");
        rd_chk(8'h08, 8'h00, "R2 cmd reads zero");
        rd_chk(8'h18, DIVH, "R2 upper divider");
        rd_chk(8'h5C, DIVL, "R2 lower divider alias");
        rd_chk(8'h24, 8'h00, "R2 unmapped");
        rd_chk(8'h40, 8'h40, "R2 mode unchanged");
        // R6 transmit
        wr(8'h0C, 8'hA5);
        @(negedge clk); chk("R6 held while disabled", tx_valid, 0); idle();
        rd_chk(8'h04, 8'h00, "R6 empty cleared");
        wr(8'h08, 8'h04);
        @(negedge clk); chk("R6 sent on enable", tx_valid, 1); chk("R6 data", tx_data, 8'hA5); idle();
        rd_chk(8'h04, 8'h0C, "R7 tx ready and empty");
        wr(8'h0C, 8'h3C);
        @(negedge clk); chk("R6 direct send", tx_valid, 1); chk("R6 data 2", tx_data, 8'h3C); idle();
        // R5 reserved codes
        wr(8'h08, 8'h0F);
        rd_chk(8'h04, 8'h0C, "R5 reserved ignored");
        chk("R5 rx stays off", rx_ready, 0);
        // R4 transmitter reset
        wr(8'h08, 8'h30);
        rd_chk(8'h04, 8'h08, "R4 tx reset");
        wr(8'h08, 8'h05);
        rd_chk(8'h04, 8'h0C, "R5 both enabled");
        chk("R5 rx on", rx_ready, 1);
        // R7 receive FIFO, R9 full-select mode
        wr(8'h14, 8'h02);
        push(8'h11); push(8'h22); push(8'h33);
        rd_chk(8'h04, 8'h0D, "R7 data ready");
        rd_chk(8'h14, 8'h01, "R9 full-select not full");
        chk("R10 masked off", irq, 0);
        push(8'h44);
        @(negedge clk); chk("R7 not ready when full", rx_ready, 0); idle();
        rd_chk(8'h04, 8'h0F, "R7 full");
        rd_chk(8'h14, 8'h03, "R9 full cause");
        chk("R10 irq on full", irq, 1);
        push(8'h55);
        rd_chk(8'h0C, 8'h11, "R7 oldest first");
        rd_chk(8'h0C, 8'h22, "R7 second");
        rd_chk(8'h0C, 8'h33, "R7 third");
        rd_chk(8'h0C, 8'h44, "R7 full drop");
        rd_chk(8'h0C, 8'h00, "R7 empty read zero");
        rd_chk(8'h04, 8'h0C, "R7 drained");
        // R9 ready-select mode
        wr(8'h08, 8'h10);
        wr(8'h00, 8'h00);
        push(8'h66);
        rd_chk(8'h14, 8'h03, "R9 ready cause");
        rd_chk(8'h0C, 8'h66, "R7 single byte");
        // R10 timing
        wr(8'h14, 8'h00);
        idle();
        wr(8'h14, 8'h01);
        @(negedge clk); chk("R10 one-cycle lag", irq, 0); idle();
        @(negedge clk); chk("R10 irq rises", irq, 1); idle();
        // R8 break on a full FIFO with receiver disabled
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
        wr(8'h08, 8'h02);
        brk();
        rd_chk(8'h14, 8'h07, "R8 break cause");
        rd_chk(8'h0C, 8'hA1, "R8 keep 1");
        rd_chk(8'h0C, 8'hA2, "R8 keep 2");
        rd_chk(8'h0C, 8'hA3, "R8 keep 3");
        rd_chk(8'h0C, 8'h00, "R8 newest overwritten");
        wr(8'h08, 8'h50);
        rd_chk(8'h14, 8'h01, "R4 break cause cleared");
        // R4 receiver reset and no-effect actions
        wr(8'h08, 8'h01);
        push(8'hB1); push(8'hB2);
        wr(8'h08, 8'h20);
        rd_chk(8'h04, 8'h0C, "R4 rx reset empties");
        chk("R4 rx disabled", rx_ready, 0);
        wr(8'h08, 8'h40); wr(8'h08, 8'h60); wr(8'h08, 8'h70);
        rd_chk(8'h04, 8'h0C, "R4 other actions no effect");
        rd_chk(8'h14, 8'h01, "R4 int status unchanged");
        idle();
        finish_run();
    end
endmodule